// File: doc/BRIEF.md
# Circular Return Address Stack

This block keeps the return addresses of a small processor core. When the core takes a subroutine call or branches to an interrupt handler, it raises a push strobe and presents the full program counter. The block stores that value as the newest entry. When the core executes any kind of return, it raises a pop strobe, and the newest entry is handed back as the resume address.

The storage is a ring of eight 13-bit slots addressed by a hidden 3-bit pointer. Neither the pointer nor the slots appear in any memory map or register bank. The stack never reports full or empty. A ninth outstanding push quietly replaces the oldest slot. Popping beyond the pushes made so far wraps the pointer and returns whatever the slot still holds.

The top-of-stack output is combinational from the stored slot, so the core can use it as the return target in the same cycle that it asserts pop.

Top module: `ras_stack`

## Requirements
- R1: A push stores `push_addr` as a 13-bit entry, and from the next cycle `tos` shows that value.
- R2: During a cycle with `pop_en` high, `tos` already shows the entry being returned. After the clock edge, `tos` shows the next older entry.
- R3: The ring holds 8 entries. The ninth push without an intervening pop overwrites the slot of the first push, so the pushed values come back newest first for exactly the last eight.
- R4: Popping past the pushes made so far wraps the pointer modulo 8 and returns the stale slot contents. No flag or other indication is given. After the 9 pushes of R3, the eighth pop presents the newest value again.
- R5: When `push_en` and `pop_en` are high in the same cycle, the push is performed and the pop is ignored. The depth therefore grows by one.
- R6: Synchronous active-high `rst` returns the pointer to slot 0 and leaves the slot contents untouched. Right after reset, `tos` shows slot 7, and the first push lands in slot 0.
- R7: In a cycle with neither strobe high, the pointer, the slots and `tos` are unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the pointer |
| push_en | input | 1 | Store `push_addr` as the new top |
| pop_en | input | 1 | Remove the top entry |
| push_addr | input | 13 | Return address to store |
| tos | output | 13 | Current top-of-stack entry |

## Verification
A push and a pop can be requested in the same cycle. The bench provokes this by raising both strobes with a fresh address while older entries are live. The collision is judged from what follows: `tos` must show the new address, and the later pops must first return the new address and then the older entries in order. This proves that no entry was lost to the ignored pop. A second overlap, a pop arriving right at ring wrap, is covered by popping a ninth-deep stack until its stale data reappears.

// File: rtl/ras_pkg.sv
package ras_pkg;

    parameter int ADDR_W = 13;
    parameter int DEPTH  = 8;
    localparam int PTR_W = $clog2(DEPTH);

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PTR_W-1:0]  ptr_t;

    localparam ptr_t LAST_SLOT = ptr_t'(DEPTH - 1);

    typedef enum logic [1:0] {
        OP_IDLE = 2'd0,
        OP_PUSH = 2'd1,
        OP_POP  = 2'd2
    } op_e;

    typedef struct packed {
        op_e   op;
        addr_t data;
    } req_t;

    // modulo-DEPTH step in either direction
    function automatic ptr_t ptr_step(input ptr_t p, input logic up);
        ptr_t r;
        if (up) r = (p == LAST_SLOT) ? '0 : ptr_t'(p + 1'b1);
        else    r = (p == '0) ? LAST_SLOT : ptr_t'(p - 1'b1);
        return r;
    endfunction

endpackage

// File: rtl/ras_ctrl.sv
module ras_ctrl
    import ras_pkg::*;
(
    input  logic  push_en,
    input  logic  pop_en,
    input  addr_t push_addr,
    output req_t  req
);
    // push outranks pop when both arrive together
    always_comb begin
        req.data = push_addr;
        if (push_en)     req.op = OP_PUSH;
        else if (pop_en) req.op = OP_POP;
        else             req.op = OP_IDLE;
    end
endmodule

// File: rtl/ras_ptr.sv
module ras_ptr
    import ras_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  op_e  op,
    output ptr_t wr_ptr,
    output ptr_t top_ptr
);
    ptr_t cur_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            unique case (op)
                OP_PUSH: cur_q <= ptr_step(cur_q, 1'b1);
                OP_POP:  cur_q <= ptr_step(cur_q, 1'b0);
                default: cur_q <= cur_q;
            endcase
        end
    end

    assign wr_ptr  = cur_q;
    assign top_ptr = ptr_step(cur_q, 1'b0);
endmodule

// File: rtl/ras_store.sv
module ras_store
    import ras_pkg::*;
(
    input  logic  clk,
    input  logic  we,
    input  ptr_t  waddr,
    input  addr_t wdata,
    input  ptr_t  raddr,
    output addr_t rdata
);
    addr_t rd_bus [DEPTH];

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        addr_t cell_q;
        always_ff @(posedge clk) begin
            if (we && (waddr == ptr_t'(i)))
                cell_q <= wdata;
        end
        assign rd_bus[i] = cell_q;
    end

    assign rdata = rd_bus[raddr];
endmodule

// File: rtl/ras_stack.sv
module ras_stack
    import ras_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              push_en,
    input  logic              pop_en,
    input  logic [ADDR_W-1:0] push_addr,
    output logic [ADDR_W-1:0] tos
);
    req_t req;
    ptr_t wr_ptr;
    ptr_t top_ptr;

    ras_ctrl u_ctrl (
        .push_en   (push_en),
        .pop_en    (pop_en),
        .push_addr (push_addr),
        .req       (req)
    );

    ras_ptr u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op      (req.op),
        .wr_ptr  (wr_ptr),
        .top_ptr (top_ptr)
    );

    ras_store u_store (
        .clk   (clk),
        .we    (req.op == OP_PUSH),
        .waddr (wr_ptr),
        .wdata (req.data),
        .raddr (top_ptr),
        .rdata (tos)
    );
endmodule

// File: rtl/ras_stack_chk.sv
module ras_stack_chk
    import ras_pkg::*;
(
    input logic  clk,
    input logic  rst,
    input logic  push_en,
    input logic  pop_en,
    input addr_t push_addr,
    input addr_t tos,
    input ptr_t  ptr
);
    AST_PUSH_SHOWN: assert property (@(posedge clk) disable iff (rst)
        push_en && !pop_en |=> tos == $past(push_addr)); // R1

    AST_PTR_DOWN: assert property (@(posedge clk) disable iff (rst)
        pop_en && !push_en |=> ptr == ptr_step($past(ptr), 1'b0)); // R4

    AST_PTR_UP: assert property (@(posedge clk) disable iff (rst)
        push_en |=> ptr == ptr_step($past(ptr), 1'b1)); // R3

    AST_PUSH_WINS: assert property (@(posedge clk) disable iff (rst)
        push_en && pop_en |=> tos == $past(push_addr)); // R5

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !push_en && !pop_en |=> $stable(tos) && $stable(ptr)); // R7

    AST_RESET_PTR: assert property (@(posedge clk)
        $past(rst) |-> ptr == '0); // R6
endmodule

bind ras_stack ras_stack_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .push_en   (push_en),
    .pop_en    (pop_en),
    .push_addr (push_addr),
    .tos       (tos),
    .ptr       (wr_ptr)
);

// File: tb/ras_stack_bench.sv
module ras_stack_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        push_en = 1'b0;
    logic        pop_en = 1'b0;
    logic [12:0] push_addr = '0;
    logic [12:0] tos;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ras_stack u_ras_stack (
        .clk(clk), .rst(rst), .push_en(push_en), .pop_en(pop_en),
        .push_addr(push_addr), .tos(tos)
    );

    typedef struct packed {
        logic        psh;
        logic        pp;
        logic [12:0] a;
        logic [12:0] e;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 1'b0, 13'h0100, 13'h0100},  // R1
        '{1'b1, 1'b0, 13'h0200, 13'h0200},  // R1
        '{1'b1, 1'b0, 13'h0300, 13'h0300},  // R1
        '{1'b0, 1'b1, 13'h0000, 13'h0200},  // R2
        '{1'b1, 1'b0, 13'h1FFF, 13'h1FFF},  // R1
        '{1'b1, 1'b1, 13'h0ABC, 13'h0ABC},  // R5
        '{1'b0, 1'b1, 13'h0000, 13'h1FFF},  // R5
        '{1'b0, 1'b1, 13'h0000, 13'h0200},  // R2
        '{1'b0, 1'b1, 13'h0000, 13'h0100},  // R2
        '{1'b0, 1'b0, 13'h0000, 13'h0100}   // R7
    };

    task automatic check(input string tag, input logic [12:0] exp);
        checks++;
        if (tos !== exp) begin
            errors++;
            $display("FAIL %s tos=%h expected=%h", tag, tos, exp);
        end
    endtask

    // apply one cycle of strobes, return sampled after the edge
    task automatic step(input logic ps, input logic pp, input logic [12:0] a);
        @(negedge clk);
        push_en = ps; pop_en = pp; push_addr = a;
        @(posedge clk);
        #1;
        push_en = 1'b0; pop_en = 1'b0;
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [12:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;

        // table walk
        for (int i = 0; i < NV; i++) begin
            step(VECS[i].psh, VECS[i].pp, VECS[i].a);
            check($sformatf("R1/R2/R5/R7 vec%0d", i), VECS[i].e);
        end

        // R2: same-cycle visibility of popped entry
        step(1'b1, 1'b0, 13'h0777);
        step(1'b1, 1'b0, 13'h0888);
        @(negedge clk);
        pop_en = 1'b1;
        #1 check("R2 tos during pop", 13'h0888);
        @(posedge clk); #1;
        pop_en = 1'b0;
        check("R2 tos after pop", 13'h0777);

        // R7: idle cycles hold tos
        for (int k = 0; k < 3; k++) begin
            step(1'b0, 1'b0, 13'h1234);
            check("R7 idle hold", 13'h0777);
        end

        // R3/R4: nine pushes then eight pops
        for (int k = 0; k < 9; k++)
            step(1'b1, 1'b0, 13'h1000 + 13'(k));
        check("R3 top after nine pushes", 13'h1008);
        for (int k = 1; k <= 7; k++) begin
            step(1'b0, 1'b1, 13'h0);
            check($sformatf("R3 pop %0d", k), 13'h1008 - 13'(k));
        end
        step(1'b0, 1'b1, 13'h0);
        check("R4 underflow wraps to stale newest", 13'h1008);
        step(1'b0, 1'b1, 13'h0);
        check("R4 continued wrap", 13'h1007);

        // R6: reset clears pointer only
        @(negedge clk) rst = 1'b1;
        @(negedge clk) rst = 1'b0;
        for (int k = 0; k < 8; k++)
            step(1'b1, 1'b0, 13'h0A00 + 13'(k));
        for (int k = 0; k < 3; k++)
            step(1'b1, 1'b0, 13'h0B00 + 13'(k));
        check("R6 pre-reset top", 13'h0B02);
        @(negedge clk) rst = 1'b1;
        @(posedge clk); #1;
        rst = 1'b0;
        check("R6 tos shows slot 7 after reset", 13'h0A07);
        v = 13'h0C0C;
        step(1'b1, 1'b0, v);
        check("R6 push after reset", v);
        step(1'b0, 1'b1, 13'h0);
        check("R6 pop back to slot 7", 13'h0A07);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule